// File: doc/BRIEF.md
# Flash Program/Erase Status Engine

This block models a small sectored flash byte array together with the embedded controller that programs and erases it. A host issues one request per cycle on a simple bus. Each request is a read, a byte program, a sector erase, a whole-array erase or a controller reset. While a program or erase is running, every read returns a status byte instead of array data. The status byte holds a data-polling bit, a toggle bit, an error bit and an erase-window bit. A registered ready output shows whether an embedded operation is in progress.

Programming can only clear bits. An erase sets a whole sector, or the whole array, back to 0xFF, one byte per cycle. A sector erase first opens an acceptance window. A second sector-erase request inside that window adds its sector to the same erase and closes the window at once. If the host asks for a 1 in a bit that is already 0, the controller enters an error state. It stays there until a reset request arrives. Program time, window length and erase settle time are parameters in clock cycles. The program time must be at least 2. The array holds 2^ADDR_W bytes in 2^SECT_W equal sectors, and the sector number is the top SECT_W address bits.

Top module: `flash_status_engine`

## Requirements
- R1: After reset `ready_o` is 1 and `rd_valid_o` is 0, and every array byte reads 0xFF.
- R2: A program request (`req_op`=1) accepted while idle stores old AND new data at `req_addr` after PROG_CYC cycles. A read returns that value once the block is ready again.
- R3: A program that asks for a 1 in a bit currently 0 leaves the array unchanged and enters an error state once the program time ends. In that state `ready_o` is 1 and status reads show bit 5 = 1. Every request except reset (`req_op`=4) is ignored until a reset request arrives.
- R4: A read (`req_op`=0) taken while not idle returns status. Bit 7 is the complement of bit 7 of the data being programmed, and 0 during an erase. Bit 6 inverts on each successive status read. Bit 5 is 1 only in the error state. Bits 4, 2, 1 and 0 are 0.
- R5: A sector erase (`req_op`=2) taken while idle selects the sector `req_addr[ADDR_W-1 -: SECT_W]` and holds status bit 3 at 0 for WIN_CYC cycles. Bit 3 then reads 1 while the erase runs. The selected sector ends at 0xFF and the other sectors keep their contents.
- R6: A second sector-erase request inside the window adds its sector to the erase, and bit 3 reads 1 from the next cycle on.
- R7: A bulk erase (`req_op`=3) taken while idle sets every byte to 0xFF.
- R8: `ready_o` drops in the cycle after a program or erase request is accepted. It stays 0 until that operation ends, then rises again.
- R9: While busy, program, bulk erase and reset requests are ignored. A sector-erase request is ignored except inside the window.
- R10: A reset request leaves the error state. Once idle, reads return array data and bit 6 no longer toggles.
- R11: `rd_valid_o` is 1 exactly in the cycle after a read request, and `rd_data_o` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 read, 1 program, 2 sector erase, 3 bulk erase, 4 reset |
| req_addr | input | ADDR_W | Byte address; top SECT_W bits select the sector |
| req_wdata | input | 8 | Program data |
| rd_data_o | output | 8 | Array data when idle, status byte otherwise |
| rd_valid_o | output | 1 | Read data valid |
| ready_o | output | 1 | 1 when no embedded operation is running |

## Verification
A wrong sequencer state shows up at once on `ready_o`, because `ready_o` is compared with the reference model on every clock. A status read taken in such a state also returns a wrong bit 3, bit 5 or bit 7 one cycle later. A wrong sector mask or a skipped write shows nothing while the block is busy. It only appears on the first read of the affected bytes after the block is ready again, so the bench reads bytes both inside and outside each erased sector. A toggle flop that is stuck or flips at the wrong time is caught on the second of two consecutive status reads.

// File: rtl/fse_pkg.sv
package fse_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_BERASE = 3'd3,
    OP_RESET  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_WIN, ST_EWAIT, ST_EWALK, ST_ERR
  } st_e;

  localparam int SB_POLL = 7;
  localparam int SB_TOG  = 6;
  localparam int SB_ERR  = 5;
  localparam int SB_WIN  = 3;
endpackage

// File: rtl/fse_array.sv
module fse_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fse_seq.sv
module fse_seq
  import fse_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 1800,
  parameter int WIN_CYC   = 20000,
  parameter int ERASE_CYC = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  input  logic [7:0]        mem_q,
  output st_e               state,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [7:0]        mem_wdata,
  output logic              poll_bit,
  output logic              ready_o
);
  localparam int NSECT = 1 << SECT_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXAB = (PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC;
  localparam int MAXC  = (MAXAB > ERASE_CYC) ? MAXAB : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  st_e               state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [NSECT-1:0]  mask_q, mask_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] tgt_addr_q;
  logic [7:0]        tgt_data_q;
  logic              poll_q, ready_q;

  logic is_prog, is_ser, is_ber, is_rst, bad_bits, cnt_zero;

  assign is_prog  = req_valid && (req_op == OP_PROG);
  assign is_ser   = req_valid && (req_op == OP_SERASE);
  assign is_ber   = req_valid && (req_op == OP_BERASE);
  assign is_rst   = req_valid && (req_op == OP_RESET);
  assign bad_bits = |(tgt_data_q & ~mem_q);
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mask_d  = mask_q;
    ptr_d   = ptr_q;
    case (state_q)
      ST_IDLE: begin
        if (is_prog) begin
          state_d = ST_PROG;
          cnt_d   = CNT_W'(PROG_CYC - 1);
        end else if (is_ser) begin
          state_d = ST_WIN;
          cnt_d   = CNT_W'(WIN_CYC - 1);
          mask_d  = NSECT'(1) << req_addr[ADDR_W-1 -: SECT_W];
        end else if (is_ber) begin
          state_d = ST_EWAIT;
          cnt_d   = CNT_W'(ERASE_CYC - 1);
          mask_d  = '1;
        end
      end
      ST_PROG: begin
        if (cnt_zero) state_d = bad_bits ? ST_ERR : ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_WIN: begin
        if (is_ser) begin
          mask_d  = mask_q | (NSECT'(1) << req_addr[ADDR_W-1 -: SECT_W]);
          state_d = ST_EWAIT;
          cnt_d   = CNT_W'(ERASE_CYC - 1);
        end else if (cnt_zero) begin
          state_d = ST_EWAIT;
          cnt_d   = CNT_W'(ERASE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_EWAIT: begin
        if (cnt_zero) begin
          state_d = ST_EWALK;
          ptr_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_EWALK: begin
        if (ptr_q == ADDR_W'(DEPTH - 1)) state_d = ST_IDLE;
        else                             ptr_d   = ptr_q + 1'b1;
      end
      ST_ERR: begin
        if (is_rst) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      mask_q     <= '0;
      ptr_q      <= '0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      poll_q     <= 1'b0;
      ready_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mask_q  <= mask_d;
      ptr_q   <= ptr_d;
      ready_q <= (state_d == ST_IDLE) || (state_d == ST_ERR);
      if (state_q == ST_IDLE) begin
        if (is_prog) begin
          tgt_addr_q <= req_addr;
          tgt_data_q <= req_wdata;
          poll_q     <= ~req_wdata[7];
        end else if (is_ser || is_ber) begin
          poll_q <= 1'b0;
        end
      end
    end
  end

  assign mem_we    = ((state_q == ST_PROG) && cnt_zero && !bad_bits) ||
                     ((state_q == ST_EWALK) && mask_q[ptr_q[ADDR_W-1 -: SECT_W]]);
  assign mem_waddr = (state_q == ST_EWALK) ? ptr_q : tgt_addr_q;
  assign mem_wdata = (state_q == ST_EWALK) ? 8'hFF : (mem_q & tgt_data_q);
  assign mem_raddr = (state_q == ST_PROG) ? tgt_addr_q : req_addr;
  assign state     = state_q;
  assign poll_bit  = poll_q;
  assign ready_o   = ready_q;
endmodule

// File: rtl/fse_status.sv
module fse_status
  import fse_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  input  st_e        state,
  input  logic       poll_bit,
  input  logic [7:0] mem_q,
  output logic [7:0] rd_data_o,
  output logic       rd_valid_o
);
  logic       is_rd, busy_view, sel_q, tog_q, valid_q;
  logic [7:0] stat_q, stat_d;

  assign is_rd     = req_valid && (req_op == OP_READ);
  assign busy_view = (state != ST_IDLE);

  always_comb begin
    stat_d          = '0;
    stat_d[SB_POLL] = poll_bit;
    stat_d[SB_TOG]  = tog_q;
    stat_d[SB_ERR]  = (state == ST_ERR);
    stat_d[SB_WIN]  = (state == ST_EWAIT) || (state == ST_EWALK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      sel_q   <= 1'b0;
      tog_q   <= 1'b0;
      stat_q  <= '0;
    end else begin
      valid_q <= is_rd;
      if (is_rd) begin
        sel_q <= busy_view;
        if (busy_view) begin
          stat_q <= stat_d;
          tog_q  <= ~tog_q;
        end
      end
    end
  end

  assign rd_data_o  = sel_q ? stat_q : mem_q;
  assign rd_valid_o = valid_q;
endmodule

// File: rtl/flash_status_engine.sv
module flash_status_engine
  import fse_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 1800,
  parameter int WIN_CYC   = 20000,
  parameter int ERASE_CYC = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic              ready_o
);
  st_e               seq_state;
  logic              mem_we, poll_bit, status_mode;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [7:0]        mem_wdata, mem_q;

  fse_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_q)
  );

  fse_seq #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
    .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_q(mem_q),
    .state(seq_state), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_raddr(mem_raddr), .mem_wdata(mem_wdata), .poll_bit(poll_bit),
    .ready_o(ready_o)
  );

  fse_status u_status (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .state(seq_state), .poll_bit(poll_bit), .mem_q(mem_q),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  assign status_mode = (seq_state != ST_IDLE);
endmodule

// File: rtl/fse_checker.sv
module fse_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic [7:0] rd_data_o,
  input logic       rd_valid_o,
  input logic       ready_o,
  input logic       status_mode
);
  logic rd_req, st_rd;
  assign rd_req = req_valid && (req_op == 3'd0);
  assign st_rd  = rd_req && status_mode;

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ready_o && !rd_valid_o));

  p_read_latency_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid_o);

  p_no_spurious_valid_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid_o);

  p_status_unused_zero_r4: assert property (@(posedge clk) disable iff (rst)
    st_rd |=> (rd_data_o[4] == 1'b0 && rd_data_o[2:0] == 3'b000));

  p_toggle_flips_r4: assert property (@(posedge clk) disable iff (rst)
    (st_rd && $past(st_rd) && !$past(rst)) |=> (rd_data_o[6] != $past(rd_data_o[6])));

  p_ready_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd1 && !status_mode) |=> !ready_o);

  p_error_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ready_o && status_mode && !(req_valid && req_op == 3'd4)) |=> (ready_o && status_mode));
endmodule

bind flash_status_engine fse_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .ready_o(ready_o),
  .status_mode(status_mode)
);

// File: tb/flash_status_engine_bench.sv
`timescale 1ns/1ps
module flash_status_engine_bench;
  localparam int AW = 8, SW = 2, PC = 4, WC = 6, EC = 5;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] RD = 3'd0, PG = 3'd1, SE = 3'd2, BE = 3'd3, RS = 3'd4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] rd_data_o;
  logic rd_valid_o, ready_o;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  flash_status_engine #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PC), .WIN_CYC(WC), .ERASE_CYC(EC))
    u_flash_status_engine (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_data_o(rd_data_o),
      .rd_valid_o(rd_valid_o), .ready_o(ready_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 program, 2 window, 3 settle, 4 walk, 5 error
  logic [7:0] m_mem [DEPTH];
  int m_st = 0, m_cnt = 0, m_ptr = 0;
  logic [3:0] m_mask = '0;
  logic [AW-1:0] m_tgt = '0;
  logic [7:0] m_dat = '0, exp_rd = '0;
  logic m_poll = 1'b0, m_tog = 1'b0, exp_rv = 1'b0, exp_ready = 1'b1;
  initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_tog = 1'b0; exp_rv = 1'b0; exp_ready = 1'b1; m_poll = 1'b0;
    end else begin
      exp_rv = req_valid && req_op == RD;
      if (exp_rv) begin
        if (m_st == 0) exp_rd = m_mem[req_addr];
        else begin
          exp_rd = {m_poll, m_tog, m_st == 5, 1'b0, (m_st == 3 || m_st == 4), 3'b000};
          m_tog = ~m_tog;
        end
      end
      case (m_st)
        0: if (req_valid && req_op == PG) begin
             m_st = 1; m_cnt = PC - 1; m_tgt = req_addr; m_dat = req_wdata; m_poll = ~req_wdata[7];
           end else if (req_valid && req_op == SE) begin
             m_st = 2; m_cnt = WC - 1; m_mask = 4'b1 << req_addr[AW-1:AW-SW]; m_poll = 1'b0;
           end else if (req_valid && req_op == BE) begin
             m_st = 3; m_cnt = EC - 1; m_mask = 4'hF; m_poll = 1'b0;
           end
        1: if (m_cnt == 0) begin
             if ((m_dat & ~m_mem[m_tgt]) != 0) m_st = 5;
             else begin m_mem[m_tgt] = m_mem[m_tgt] & m_dat; m_st = 0; end
           end else m_cnt--;
        2: if (req_valid && req_op == SE) begin
             m_mask |= 4'b1 << req_addr[AW-1:AW-SW]; m_st = 3; m_cnt = EC - 1;
           end else if (m_cnt == 0) begin m_st = 3; m_cnt = EC - 1; end
           else m_cnt--;
        3: if (m_cnt == 0) begin m_st = 4; m_ptr = 0; end else m_cnt--;
        4: begin
             if (m_mask[m_ptr / (DEPTH >> SW)]) m_mem[m_ptr] = 8'hFF;
             if (m_ptr == DEPTH - 1) m_st = 0; else m_ptr++;
           end
        5: if (req_valid && req_op == RS) m_st = 0;
        default: m_st = 0;
      endcase
      exp_ready = (m_st == 0 || m_st == 5);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(ready_o == exp_ready, "R8 ready vs model", ready_o, exp_ready);
      chk(rd_valid_o == exp_rv, "R11 rd_valid vs model", rd_valid_o, exp_rv);
      if (exp_rv) chk(rd_data_o == exp_rd, "R4/R2 rd_data vs model", rd_data_o, exp_rd);
    end
  end

  task automatic drive(input bit v, input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
    req_valid = v; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, RD, 8'h00, 8'h00);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 1000 && !ready_o; i++) idle();
  endtask

  task automatic read_expect(input logic [7:0] a, input logic [7:0] e, input string tag);
    drive(1'b1, RD, a, 8'h00);
    chk(rd_valid_o && rd_data_o == e, tag, rd_data_o, e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(ready_o == 1'b1, "R1 ready after reset", ready_o, 1);
    chk(rd_valid_o == 1'b0, "R1 no valid after reset", rd_valid_o, 0);
    read_expect(8'h05, 8'hFF, "R1 erased byte");
    read_expect(8'hF3, 8'hFF, "R1 erased byte high");

    drive(1'b1, PG, 8'h05, 8'hA5);
    chk(ready_o == 1'b0, "R8 busy after program", ready_o, 0);
    drive(1'b1, RD, 8'h05, 8'h00);
    chk((rd_data_o & 8'hBF) == 8'h00, "R4 program status bits", rd_data_o, 0);
    begin
      logic t0;
      t0 = rd_data_o[6];
      drive(1'b1, RD, 8'h33, 8'h00);
      chk(rd_data_o[6] == ~t0, "R4 toggle flips", rd_data_o[6], ~t0);
    end
    wait_ready();
    read_expect(8'h05, 8'hA5, "R2 programmed byte");
    drive(1'b1, PG, 8'h05, 8'h21);
    wait_ready();
    read_expect(8'h05, 8'h21, "R2 AND of old and new");

    drive(1'b1, PG, 8'h05, 8'h80);
    wait_ready();
    drive(1'b1, RD, 8'h05, 8'h00);
    chk(rd_data_o[5] == 1'b1 && rd_data_o[7] == 1'b0, "R3 error status", rd_data_o, 8'h20);
    drive(1'b1, PG, 8'h10, 8'h00);
    idle();
    drive(1'b1, RD, 8'h10, 8'h00);
    chk(rd_data_o[5] == 1'b1 && ready_o == 1'b1, "R3 error sticky", rd_data_o, 8'h20);
    drive(1'b1, RS, 8'h00, 8'h00);
    read_expect(8'h05, 8'h21, "R10 normal data after reset cmd");
    read_expect(8'h05, 8'h21, "R10 no toggle when idle");
    read_expect(8'h10, 8'hFF, "R3 ignored program in error state");

    drive(1'b1, PG, 8'h45, 8'h0F);
    wait_ready();
    drive(1'b1, SE, 8'h05, 8'h00);
    drive(1'b1, RD, 8'h00, 8'h00);
    chk(rd_data_o[3] == 1'b0 && ready_o == 1'b0, "R5 window bit3 low", rd_data_o, 0);
    repeat (8) idle();
    drive(1'b1, RD, 8'h00, 8'h00);
    chk(rd_data_o[3] == 1'b1, "R5 bit3 high after window", rd_data_o[3], 1);
    wait_ready();
    read_expect(8'h05, 8'hFF, "R5 sector erased");
    read_expect(8'h45, 8'h0F, "R5 other sector kept");

    drive(1'b1, PG, 8'h85, 8'h33);
    wait_ready();
    drive(1'b1, PG, 8'hC5, 8'h12);
    wait_ready();
    drive(1'b1, SE, 8'h40, 8'h00);
    drive(1'b1, SE, 8'h80, 8'h00);
    drive(1'b1, RD, 8'h00, 8'h00);
    chk(rd_data_o[3] == 1'b1, "R6 stacked erase closes window", rd_data_o[3], 1);
    drive(1'b1, PG, 8'h00, 8'h00);
    drive(1'b1, BE, 8'h00, 8'h00);
    wait_ready();
    read_expect(8'h45, 8'hFF, "R6 first sector erased");
    read_expect(8'h85, 8'hFF, "R6 stacked sector erased");
    read_expect(8'hC5, 8'h12, "R6 unselected sector kept");
    read_expect(8'h00, 8'hFF, "R9 program while busy ignored");

    drive(1'b1, BE, 8'h00, 8'h00);
    chk(ready_o == 1'b0, "R8 busy after bulk erase", ready_o, 0);
    wait_ready();
    chk(ready_o == 1'b1, "R8 ready after erase", ready_o, 1);
    read_expect(8'hC5, 8'hFF, "R7 bulk erase clears");
    read_expect(8'h05, 8'hFF, "R7 bulk erase clears low");
    repeat (3) idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule